// File: doc/BRIEF.md
# System configuration register bank

This block holds eleven 32-bit configuration words behind a simple word-indexed read/write port. Inside each word, every bit follows one access rule. Some bits are plain read/write. Some are reserved and always read zero. Some can only be set and stay at one until reset. One bit can only be cleared. One status flag is set by hardware and cleared by software writing one to it. A write changes storage on the clock edge that samples the strobe. A read returns registered data one cycle after the strobe, marked by a valid pulse.

Four of the words choose which source drives each external-interrupt line. Their low 16 bits go straight out of the block on a flat bus that feeds a separate multiplexer. An access to an index past the last word reads zero, changes nothing and raises a one-cycle error pulse. The port takes a word index, which is the byte offset divided by four.

Top module: `sysreg_bank`

## Requirements
- R1: After reset, word 1 (config1) reads 0x7C000001 and every other word reads 0x00000000.
- R2: In word 0 (remap) only the bits of mask 0x00000107 can be written. All other bits read zero.
- R3: In word 1 the bits of mask 0xFCFF0100 are plain read/write. Ones written to its reserved bits, for example 0x0300FE00, read back as zero.
- R4: Bit 0 of word 1 is clear-only. Writing 0 clears it. Writing 1 afterwards leaves it at 0. Only reset brings it back to 1.
- R5: Words 2 to 5 store bits 15:0 and read zero in bits 31:16. Word 2+k drives `src_sel[16k+15:16k]` from the clock edge that stores it.
- R6: Word 9 (key) stores bits 7:0. Its other bits read zero.
- R7: Bits 3:0 of word 7 (config2) are set-only. A 1 sets the bit, a 0 has no effect, and only reset clears it.
- R8: Bit 8 of word 7 is a flag. `flag_set` sets it. Writing 1 to the bit clears it, and writing 1 while the flag is clear does not set it. When `flag_set` and a write of 1 fall in the same cycle, the flag ends set.
- R9: Words 8 and 10 (write-protect) are set-only in all 32 bits until reset.
- R10: An index of 11 or more reads zero and its writes are ignored. `bus_err` pulses high in the cycle after any such access.
- R11: `bus_rvalid` is high exactly in the cycle after `bus_rd`, with `bus_rdata` valid in that cycle. When a read and a write hit the same word in one cycle, the read returns the value from before the write.
- R12: Word 6 (status) has no storage and always reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_idx | input | 4 | Word index (byte offset / 4) |
| bus_wdata | input | 32 | Write data |
| flag_set | input | 1 | Hardware event that sets the config2 flag bit |
| bus_rdata | output | 32 | Registered read data |
| bus_rvalid | output | 1 | Read data valid, one cycle after bus_rd |
| bus_err | output | 1 | One-cycle pulse after an access to an invalid index |
| src_sel | output | 64 | Four 16-bit interrupt source selection words |

## Verification
The config2 flag can receive a hardware set and a software write-one-to-clear in the same cycle. The bench provokes this by raising `flag_set` in the same cycle as a write of 0x100 to word 7. It then reads the word back and expects the flag still set, because the hardware event wins. The bench also puts a read and a write to the key word in one cycle, and expects the old value on that read and the new value on the next one.

// File: rtl/sysreg_pkg.sv
package sysreg_pkg;
  localparam int WORD_W   = 32;
  localparam int NUM_REGS = 11;
  localparam int IDX_W    = 4;
  localparam int SEL_W    = 16;
  localparam int NUM_SEL  = 4;
  localparam int SEL_BASE = 2;
  localparam int CFG2_IDX = 7;
  localparam int FLAG_BIT = 8;

  typedef logic [WORD_W-1:0] word_t;

  // Per-bit rule masks; the masks are disjoint, and any bit set in none is reserved.
  typedef struct packed {
    word_t rw;
    word_t set1;
    word_t clr0;
    word_t w1c;
    word_t init;
  } policy_t;

  function automatic policy_t policy_of(input int idx);
    policy_t p;
    p = '0;
    case (idx)
      0:          p.rw = 32'h0000_0107;
      1: begin
        p.rw   = 32'hFCFF_0100;
        p.clr0 = 32'h0000_0001;
        p.init = 32'h7C00_0001;
      end
      2, 3, 4, 5: p.rw = 32'h0000_FFFF;
      7: begin
        p.set1 = 32'h0000_000F;
        p.w1c  = 32'h0000_0100;
      end
      8, 10:      p.set1 = 32'hFFFF_FFFF;
      9:          p.rw = 32'h0000_00FF;
      default:    p = '0;
    endcase
    return p;
  endfunction
endpackage

// File: rtl/sysreg_word.sv
module sysreg_word
  import sysreg_pkg::*;
#(
  parameter policy_t POL = '0
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  we,
  input  word_t wdata,
  input  word_t hw_set,
  output word_t q
);
  word_t ones_in, keep, nxt;

  always_comb begin
    ones_in = we ? wdata : '0;
    keep    = we ? wdata : '1;
    nxt     = ((we ? wdata : q) & POL.rw)
            | ((q | ones_in) & POL.set1)
            | (q & keep & POL.clr0)
            | (((q & ~ones_in) | hw_set) & POL.w1c);
  end

  always_ff @(posedge clk) begin
    if (rst) q <= POL.init;
    else     q <= nxt;
  end
endmodule

// File: rtl/sysreg_decode.sv
module sysreg_decode #(
  parameter int IDX_W    = 4,
  parameter int NUM_REGS = 11
) (
  input  logic                bus_wr,
  input  logic                bus_rd,
  input  logic [IDX_W-1:0]    bus_idx,
  output logic [NUM_REGS-1:0] wr_hit,
  output logic                bad_access
);
  logic idx_ok;
  assign idx_ok     = (bus_idx < IDX_W'(NUM_REGS));
  assign bad_access = (bus_wr | bus_rd) & ~idx_ok;

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_hit
    assign wr_hit[i] = bus_wr & (bus_idx == IDX_W'(i));
  end
endmodule

// File: rtl/sysreg_rdmux.sv
module sysreg_rdmux #(
  parameter int IDX_W    = 4,
  parameter int NUM_REGS = 11,
  parameter int WORD_W   = 32
) (
  input  logic [NUM_REGS-1:0][WORD_W-1:0] words,
  input  logic [IDX_W-1:0]                idx,
  output logic [WORD_W-1:0]               rd_word
);
  always_comb begin
    rd_word = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (idx == IDX_W'(i)) rd_word = words[i];
    end
  end
endmodule

// File: rtl/sysreg_bank.sv
module sysreg_bank #(
  parameter int IDX_W   = sysreg_pkg::IDX_W,
  parameter int SEL_W   = sysreg_pkg::SEL_W,
  parameter int NUM_SEL = sysreg_pkg::NUM_SEL
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     bus_wr,
  input  logic                     bus_rd,
  input  logic [IDX_W-1:0]         bus_idx,
  input  logic [31:0]              bus_wdata,
  input  logic                     flag_set,
  output logic [31:0]              bus_rdata,
  output logic                     bus_rvalid,
  output logic                     bus_err,
  output logic [NUM_SEL*SEL_W-1:0] src_sel
);
  import sysreg_pkg::*;

  localparam int NREG = NUM_REGS;

  logic [NREG-1:0]             wr_hit;
  logic                        bad_access;
  logic [NREG-1:0][WORD_W-1:0] regs;
  word_t                       rd_word;
  word_t                       flag_vec;

  assign flag_vec = word_t'(flag_set) << FLAG_BIT;

  sysreg_decode #(.IDX_W(IDX_W), .NUM_REGS(NREG)) u_dec (
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .bus_idx    (bus_idx),
    .wr_hit     (wr_hit),
    .bad_access (bad_access)
  );

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    localparam policy_t P = policy_of(i);
    word_t hw_in;
    if (i == CFG2_IDX) begin : g_flag
      assign hw_in = flag_vec;
    end else begin : g_noflag
      assign hw_in = '0;
    end
    sysreg_word #(.POL(P)) u_word (
      .clk    (clk),
      .rst    (rst),
      .we     (wr_hit[i]),
      .wdata  (bus_wdata),
      .hw_set (hw_in),
      .q      (regs[i])
    );
  end

  sysreg_rdmux #(.IDX_W(IDX_W), .NUM_REGS(NREG), .WORD_W(WORD_W)) u_mux (
    .words   (regs),
    .idx     (bus_idx),
    .rd_word (rd_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
      bus_err    <= 1'b0;
    end else begin
      bus_rvalid <= bus_rd;
      bus_err    <= bad_access;
      if (bus_rd) bus_rdata <= rd_word;
    end
  end

  for (genvar k = 0; k < NUM_SEL; k++) begin : g_sel
    assign src_sel[k*SEL_W +: SEL_W] = regs[SEL_BASE+k][SEL_W-1:0];
  end
endmodule

// File: rtl/sysreg_chk.sv
module sysreg_chk #(
  parameter int IDX_W    = 4,
  parameter int NUM_REGS = 11,
  parameter int SEL_W    = 16,
  parameter int NUM_SEL  = 4,
  parameter int SEL_BASE = 2
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     bus_wr,
  input logic                     bus_rd,
  input logic [IDX_W-1:0]         bus_idx,
  input logic [SEL_W-1:0]         sel_wdata,
  input logic [31:0]              bus_rdata,
  input logic                     bus_rvalid,
  input logic                     bus_err,
  input logic [NUM_SEL*SEL_W-1:0] src_sel
);
  logic bad_idx, sel_hit;
  assign bad_idx = bus_idx >= IDX_W'(NUM_REGS);
  assign sel_hit = bus_wr && bus_idx >= IDX_W'(SEL_BASE) && bus_idx < IDX_W'(SEL_BASE + NUM_SEL);

  AST_ERR_RAISE: assert property (@(posedge clk) disable iff (rst)
    ((bus_wr || bus_rd) && bad_idx) |=> bus_err); // R10
  AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (rst)
    bus_err |-> ($past(bus_wr || bus_rd) && $past(bad_idx))); // R10
  AST_BAD_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bad_idx) |=> (bus_rdata == '0)); // R10
  AST_RVALID_RISE: assert property (@(posedge clk) disable iff (rst)
    bus_rd |=> bus_rvalid); // R11
  AST_RVALID_CAUSE: assert property (@(posedge clk) disable iff (rst)
    bus_rvalid |-> $past(bus_rd)); // R11
  AST_SEL_HOLD: assert property (@(posedge clk) disable iff (rst)
    !sel_hit |=> $stable(src_sel)); // R5
  AST_SEL_LOAD: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_idx == IDX_W'(SEL_BASE)) |=> (src_sel[SEL_W-1:0] == $past(sel_wdata))); // R5
endmodule

bind sysreg_bank sysreg_chk #(
  .IDX_W(sysreg_pkg::IDX_W), .NUM_REGS(sysreg_pkg::NUM_REGS), .SEL_W(sysreg_pkg::SEL_W),
  .NUM_SEL(sysreg_pkg::NUM_SEL), .SEL_BASE(sysreg_pkg::SEL_BASE)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .bus_wr     (bus_wr),
  .bus_rd     (bus_rd),
  .bus_idx    (bus_idx),
  .sel_wdata  (bus_wdata[sysreg_pkg::SEL_W-1:0]),
  .bus_rdata  (bus_rdata),
  .bus_rvalid (bus_rvalid),
  .bus_err    (bus_err),
  .src_sel    (src_sel)
);

// File: tb/tb_sysreg_bank.sv
`timescale 1ns/1ps
module tb_sysreg_bank;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0, flag_set = 1'b0;
  logic [3:0]  bus_idx = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid, bus_err;
  logic [63:0] src_sel;

  always #4 clk = ~clk;

  sysreg_bank dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_idx(bus_idx),
    .bus_wdata(bus_wdata), .flag_set(flag_set), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .bus_err(bus_err), .src_sel(src_sel)
  );

  typedef struct {
    bit          is_rd;
    bit          exp_err;
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t q[$];
  int total = 0, bad = 0;
  bit acc_q = 1'b0;
  bit done = 1'b0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Access cycle: drive at a falling edge, release at the next one.
  task automatic access(input bit wr, input bit rd, input int idx, input logic [31:0] wd,
                        input bit hw, input logic [31:0] exp, input string tag);
    item_t it;
    @(negedge clk);
    bus_wr = wr; bus_rd = rd; bus_idx = 4'(idx); bus_wdata = wd; flag_set = hw;
    if (wr || rd) begin
      it.is_rd = rd; it.exp_err = (idx >= 11); it.exp = exp; it.tag = tag;
      q.push_back(it);
    end
    @(negedge clk);
    bus_wr = 0; bus_rd = 0; flag_set = 0; bus_wdata = '0;
  endtask

  task automatic wr(input int idx, input logic [31:0] d, input string tag);
    access(1, 0, idx, d, 0, '0, tag);
  endtask
  task automatic rd(input int idx, input logic [31:0] e, input string tag);
    access(0, 1, idx, '0, 0, e, tag);
  endtask

  always @(posedge clk) acc_q <= rst ? 1'b0 : (bus_wr | bus_rd);

  // Monitor: compares results against the queued expectations.
  always @(negedge clk) begin
    if (acc_q && q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      check(bus_err == it.exp_err, {it.tag, " err"}, 32'(bus_err), 32'(it.exp_err));
      check(bus_rvalid == it.is_rd, {it.tag, " rvalid"}, 32'(bus_rvalid), 32'(it.is_rd));
      if (it.is_rd) check(bus_rdata == it.exp, {it.tag, " rdata"}, bus_rdata, it.exp);
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    check(bus_rvalid == 0 && bus_err == 0 && src_sel == '0, "R1 outputs at reset", 32'(src_sel), 0);
    for (int i = 0; i < 11; i++) rd(i, (i == 1) ? 32'h7C00_0001 : 32'h0, (i == 6) ? "R12 status" : "R1 reset value");

    wr(0, 32'hFFFF_FFFF, "R2 remap"); rd(0, 32'h0000_0107, "R2 remap mask");
    wr(0, 32'h0, "R2 remap"); rd(0, 32'h0, "R2 remap clear");

    wr(1, 32'hFFFF_FFFF, "R3 cfg1"); rd(1, 32'hFCFF_0101, "R3 cfg1 writable");
    wr(1, 32'h0300_FE01, "R3 cfg1"); rd(1, 32'h0000_0001, "R3 cfg1 reserved");

    wr(1, 32'h0, "R4 cfg1"); rd(1, 32'h0, "R4 clear bit0");
    wr(1, 32'h7C00_0001, "R4 cfg1"); rd(1, 32'h7C00_0000, "R4 bit0 stays clear");

    wr(2, 32'hFFFF_0010, "R5 sel0"); rd(2, 32'h0000_0010, "R5 sel0 read");
    check(src_sel[15:0] == 16'h0010, "R5 src_sel lane0", 32'(src_sel[15:0]), 32'h10);
    wr(5, 32'h1234_ABCD, "R5 sel3"); rd(5, 32'h0000_ABCD, "R5 sel3 read");
    check(src_sel[63:48] == 16'hABCD && src_sel[15:0] == 16'h0010, "R5 src_sel lane3",
          32'(src_sel[63:48]), 32'hABCD);

    wr(9, 32'hFFFF_FFA5, "R6 key"); rd(9, 32'h0000_00A5, "R6 key mask");

    wr(7, 32'h0000_0100, "R8 cfg2"); rd(7, 32'h0, "R8 w1 does not set flag");
    wr(7, 32'h5, "R7 cfg2"); wr(7, 32'h0, "R7 cfg2"); rd(7, 32'h5, "R7 set-only hold");
    wr(7, 32'hA, "R7 cfg2"); rd(7, 32'hF, "R7 set-only accumulate");

    access(0, 0, 0, '0, 1, '0, "R8 hw"); rd(7, 32'h10F, "R8 hw set");
    wr(7, 32'h100, "R8 clear"); rd(7, 32'hF, "R8 w1 clears");
    access(0, 0, 0, '0, 1, '0, "R8 hw"); access(1, 0, 7, 32'h100, 1, '0, "R8 collide");
    rd(7, 32'h10F, "R8 hw wins collision");
    wr(7, 32'h100, "R8 clear"); rd(7, 32'hF, "R8 clear after collision");

    wr(8, 32'hDEAD_BEEF, "R9 wp1"); wr(8, 32'h0, "R9 wp1"); rd(8, 32'hDEAD_BEEF, "R9 wp1 hold");
    wr(8, 32'h2152_4110, "R9 wp1"); rd(8, 32'hFFFF_FFFF, "R9 wp1 accumulate");
    wr(10, 32'h1, "R9 wp2"); wr(10, 32'h0, "R9 wp2"); rd(10, 32'h1, "R9 wp2 hold");

    wr(11, 32'hFFFF_FFFF, "R10 bad write"); rd(11, 32'h0, "R10 bad read");
    wr(15, 32'hFFFF_FFFF, "R10 bad write"); rd(15, 32'h0, "R10 bad read top");
    rd(0, 32'h0, "R10 remap unchanged"); rd(9, 32'hA5, "R10 key unchanged");
    rd(2, 32'h10, "R10 sel unchanged");

    access(1, 1, 9, 32'h3C, 0, 32'hA5, "R11 read old on collision");
    rd(9, 32'h3C, "R11 new value next read");

    @(negedge clk); rst = 1; @(negedge clk); @(negedge clk); rst = 0;
    rd(8, 32'h0, "R9 reset clears wp1"); rd(1, 32'h7C00_0001, "R4 reset restores bit0");
    rd(7, 32'h0, "R7 reset clears cfg2");
    check(src_sel == '0, "R5 src_sel after reset", src_sel[31:0], 0);

    repeat (2) @(negedge clk);
    check(q.size() == 0, "R11 all results seen", 32'(q.size()), 0);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule